// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Sequencer

This block owns an external power-enable output for a system that is powered down by its real-time clock and woken up again by board-level signals. A dedicated compare alarm watches the calendar time that a separate calendar counter supplies. When every field of that time equals the programmed alarm time, the block records the event in a sticky status flag. It can also raise an interrupt. If power control is switched on, the same event turns the power-enable output off.

While the output is off, up to four external wakeup pins are watched. Each pin has its own enable and its own polarity. Any enabled pin that sits at its active level turns the output back on, and the block keeps a mask of the pins that caused that wakeup. The pins pass through a short synchronizer. Debounce is left to the board.

The register set is reached through a simple byte-addressed port. Writes take effect in one cycle. A read returns registered data in the cycle after it is issued.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1, `irq` is 0, the status register (0x44) reads 0, and the power configuration register (0x98) reads 0x000000F0. All wake enables are clear and every polarity bit is 1.
- R2: The six alarm bytes are written and read at 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94, matching `cal_time` bytes 0 to 5. An event occurs only on the cycle in which the full 48-bit match begins, and it sets status bit 7. A partial match sets nothing. A match that is still present after reset, or after the flag has been cleared, raises no further event.
- R3: Writing 1 to bit 7 of 0x44 clears the alarm flag. Writing 0 there leaves it unchanged.
- R4: `irq` is high exactly when the alarm flag is set and bit 4 of the interrupt enable register (0x48) is 1.
- R5: When bit 16 of 0x98 is 1, an alarm event drives `pwr_en` to 0. When bit 16 is 0, an alarm event leaves `pwr_en` at 1.
- R6: While `pwr_en` is 0, a wake pin x whose enable bit x of 0x98 is 1 and whose level is active raises `pwr_en` within three clock cycles. Polarity bit 4+x of 0x98 selects the active level: 1 means active low and 0 means active high.
- R7: Wake pins that are disabled, or that sit at their inactive level, never raise `pwr_en`.
- R8: On a wakeup, bits 23:20 of 0x98 capture the mask of the enabled pins that were active. Writes to those bits are ignored.
- R9: While `pwr_en` is 1, wake pins have no effect and the captured mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| cal_time | input | 48 | Calendar time, byte 0 seconds through byte 5 year |
| wake_pins | input | 4 | External wakeup inputs, asynchronous |
| pwr_en | output | 1 | Power-enable output, 1 = on |
| irq | output | 1 | Alarm interrupt |

## Verification
The checks take `cal_time` to be held steady for a few cycles around each change, as a calendar that ticks far more slowly than the bus clock would hold it. They also take the wake pins to be quasi-static, because nothing filters glitches on them. The stimulus never changes more than one alarm-relevant input in the same cycle. It never issues a flag-clear write in the cycle an alarm event fires, and it holds each wake pattern for several cycles before sampling. Power-off is always reached with the wake enables cleared first, so that the event under test is the only cause of each edge on `pwr_en`.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 32;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h44;
  localparam logic [ADDR_W-1:0] ADR_IRQEN  = 8'h48;
  localparam logic [ADDR_W-1:0] ADR_ALARM0 = 8'h80;
  localparam logic [ADDR_W-1:0] ADR_PWRCFG = 8'h98;
  localparam int ALARM_STRIDE = 4;
  localparam int FLAG_BIT     = 7;
  localparam int IE_BIT       = 4;
  localparam int POL_LSB      = 4;
  localparam int CTL_BIT      = 16;
  localparam int SRC_LSB      = 20;

  typedef enum logic {ST_ON = 1'b0, ST_OFF = 1'b1} pwr_state_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match import pwr_seq_pkg::*; #(
  parameter int FIELDS  = 6,
  parameter int FIELD_W = 8,
  localparam int TIME_W = FIELDS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [FIELD_W-1:0] wr_byte,
  input  logic [TIME_W-1:0] cal_time,
  output logic [TIME_W-1:0] alarm_time,
  output logic              evt
);
  logic match_now;
  logic match_prev;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] FADR = ADR_ALARM0 + ADDR_W'(i * ALARM_STRIDE);
    always_ff @(posedge clk) begin
      if (rst) alarm_time[i*FIELD_W +: FIELD_W] <= '0;
      else if (wr_en && wr_addr == FADR) alarm_time[i*FIELD_W +: FIELD_W] <= wr_byte;
    end
  end

  assign match_now = (cal_time == alarm_time);

  // match_prev starts high so a match already present at reset is not an event
  always_ff @(posedge clk) begin
    if (rst) begin
      match_prev <= 1'b1;
      evt        <= 1'b0;
    end else begin
      match_prev <= match_now;
      evt        <= match_now && !match_prev;
    end
  end
endmodule

// File: rtl/wake_qualify.sv
module wake_qualify #(
  parameter int NUM_WAKE = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_WAKE-1:0] pins,
  input  logic [NUM_WAKE-1:0] enable,
  input  logic [NUM_WAKE-1:0] active_low,
  output logic [NUM_WAKE-1:0] hit
);
  logic [NUM_WAKE-1:0] sync_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pins;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  // level XOR polarity gives the active state; 1 = active low inverts
  assign hit = enable & (sync_q[STAGES-1] ^ active_low);
endmodule

// File: rtl/pwr_state.sv
module pwr_state import pwr_seq_pkg::*; #(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_en,
  input  logic                alarm_evt,
  input  logic [NUM_WAKE-1:0] hit,
  output logic                pwr_en,
  output logic [NUM_WAKE-1:0] src
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON:  if (alarm_evt && ctl_en) state_d = ST_OFF;
      ST_OFF: if (|hit)                state_d = ST_ON;
      default: state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ON;
      pwr_en  <= 1'b1;
      src     <= '0;
    end else begin
      state_q <= state_d;
      pwr_en  <= (state_d == ST_ON);
      if (state_q == ST_OFF && |hit) src <= hit;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl import pwr_seq_pkg::*; #(
  parameter int NUM_WAKE    = 4,
  parameter int FIELDS      = 6,
  parameter int FIELD_W     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int TIME_W     = FIELDS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [TIME_W-1:0] cal_time,
  input  logic [NUM_WAKE-1:0] wake_pins,
  output logic              pwr_en,
  output logic              irq
);
  logic [NUM_WAKE-1:0] wake_en;
  logic [NUM_WAKE-1:0] wake_pol;
  logic                ctl_en;
  logic                flag;
  logic                irq_en;
  logic [TIME_W-1:0]   alarm_time;
  logic                alarm_evt;
  logic [NUM_WAKE-1:0] wake_hit;
  logic [NUM_WAKE-1:0] wake_src;
  logic [DATA_W-1:0]   rd_mux;
  logic                clr_req;

  alarm_match #(.FIELDS(FIELDS), .FIELD_W(FIELD_W)) u_alarm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_data[FIELD_W-1:0]), .cal_time(cal_time),
    .alarm_time(alarm_time), .evt(alarm_evt)
  );

  wake_qualify #(.NUM_WAKE(NUM_WAKE), .STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst(rst), .pins(wake_pins), .enable(wake_en),
    .active_low(wake_pol), .hit(wake_hit)
  );

  pwr_state #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .alarm_evt(alarm_evt),
    .hit(wake_hit), .pwr_en(pwr_en), .src(wake_src)
  );

  assign clr_req = wr_en && wr_addr == ADR_STATUS && wr_data[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_en  <= '0;
      wake_pol <= '1;
      ctl_en   <= 1'b0;
      irq_en   <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADR_PWRCFG) begin
        wake_en  <= wr_data[NUM_WAKE-1:0];
        wake_pol <= wr_data[POL_LSB +: NUM_WAKE];
        ctl_en   <= wr_data[CTL_BIT];
      end
      if (wr_en && wr_addr == ADR_IRQEN) irq_en <= wr_data[IE_BIT];
      // a new event wins over a clear in the same cycle
      if (alarm_evt)    flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  assign irq = flag && irq_en;

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      ADR_STATUS: rd_mux[FLAG_BIT] = flag;
      ADR_IRQEN:  rd_mux[IE_BIT]   = irq_en;
      ADR_PWRCFG: begin
        rd_mux[NUM_WAKE-1:0]          = wake_en;
        rd_mux[POL_LSB +: NUM_WAKE]   = wake_pol;
        rd_mux[CTL_BIT]               = ctl_en;
        rd_mux[SRC_LSB +: NUM_WAKE]   = wake_src;
      end
      default: begin
        for (int i = 0; i < FIELDS; i++)
          if (rd_addr == ADR_ALARM0 + ADDR_W'(i * ALARM_STRIDE))
            rd_mux[FIELD_W-1:0] = alarm_time[i*FIELD_W +: FIELD_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int NUM_WAKE = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                pwr_en,
  input logic                alarm_evt,
  input logic                ctl_en,
  input logic [NUM_WAKE-1:0] wake_hit,
  input logic [NUM_WAKE-1:0] wake_src,
  input logic                flag,
  input logic                clr_req
);
  // R5
  off_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> $past(alarm_evt && ctl_en));
  // R6
  on_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(|wake_hit));
  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(alarm_evt));
  // R3
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr_req));
  // R9
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wake_src) |-> $rose(pwr_en));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
  .clk(clk), .rst(rst), .pwr_en(pwr_en), .alarm_evt(alarm_evt),
  .ctl_en(ctl_en), .wake_hit(wake_hit), .wake_src(wake_src),
  .flag(flag), .clr_req(clr_req)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [47:0] cal_time = '0;
  logic [3:0]  wake_pins = 4'b0000;
  logic        pwr_en;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  localparam logic [47:0] ALM = 48'h24_06_05_12_15_30;

  // vector: {enable, polarity, pins, expect_on, expect_src}
  localparam logic [16:0] VEC [8] = '{
    {4'b0001, 4'b1111, 4'b1110, 1'b1, 4'b0001},
    {4'b0010, 4'b0000, 4'b0010, 1'b1, 4'b0010},
    {4'b0100, 4'b1111, 4'b1111, 1'b0, 4'b0000},
    {4'b0000, 4'b0000, 4'b1111, 1'b0, 4'b0000},
    {4'b1100, 4'b0100, 4'b1000, 1'b1, 4'b1100},
    {4'b1000, 4'b1000, 4'b0111, 1'b1, 4'b1000},
    {4'b0011, 4'b0011, 4'b0011, 1'b0, 4'b0000},
    {4'b1111, 4'b0000, 4'b0101, 1'b1, 4'b0101}
  };

  pwr_seq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cal_time(cal_time),
    .wake_pins(wake_pins), .pwr_en(pwr_en), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire_alarm();
    @(negedge clk); cal_time = ALM;
    wait_cyc(3);
    cal_time = 48'h0;
    wait_cyc(1);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    wait_cyc(3);
    @(negedge clk); rst = 1'b0;
    // R1 reset state (cal_time matches the zero alarm at reset: no event)
    check("R1 pwr_en", 32'(pwr_en), 1);
    check("R1 irq", 32'(irq), 0);
    rd(8'h98, r); check("R1 cfg", r, 32'h0000_00F0);
    wait_cyc(2);
    rd(8'h44, r); check("R1 status", r, 0);

    // R2 program alarm bytes and read them back
    for (int i = 0; i < 6; i++) wr(8'h80 + 8'(4 * i), 32'(ALM[8*i +: 8]));
    for (int i = 0; i < 6; i++) begin
      rd(8'h80 + 8'(4 * i), r); check("R2 alarm byte", r, 32'(ALM[8*i +: 8]));
    end
    // R2 partial match: seconds differ
    @(negedge clk); cal_time = ALM ^ 48'h1; wait_cyc(4); cal_time = '0; wait_cyc(1);
    rd(8'h44, r); check("R2 partial no flag", r, 0);

    // R5 control disabled: alarm sets flag but power stays on
    wr(8'h98, 32'h0000_00F0);
    fire_alarm();
    check("R5 ctl off keeps pwr", 32'(pwr_en), 1);
    rd(8'h44, r); check("R2 flag set", r, 32'h80);
    // R4 interrupt masking
    check("R4 irq masked", 32'(irq), 0);
    wr(8'h48, 32'h10); wait_cyc(1);
    check("R4 irq on", 32'(irq), 1);
    // R3 clear semantics
    wr(8'h44, 32'h00); rd(8'h44, r); check("R3 write0 keeps", r, 32'h80);
    wr(8'h44, 32'h80); rd(8'h44, r); check("R3 write1 clears", r, 0);
    check("R4 irq drops", 32'(irq), 0);
    // R2 held match fires once: clear while matching, no new flag
    @(negedge clk); cal_time = ALM; wait_cyc(3);
    wr(8'h44, 32'h80); wait_cyc(3);
    rd(8'h44, r); check("R2 single event", r, 0);
    cal_time = '0; wait_cyc(2);
    wr(8'h48, 32'h0);

    // R6 R7 R8 vector table
    foreach (VEC[k]) begin
      logic [3:0] en, pol, pins, src;
      logic on;
      {en, pol, pins, on, src} = VEC[k];
      @(negedge clk); wake_pins = pins;
      wr(8'h98, 32'h0001_0000 | (32'(pol) << 4));
      fire_alarm();
      check("R5 alarm powers off", 32'(pwr_en), 0);
      wr(8'h44, 32'h80);
      wr(8'h98, 32'h0001_0000 | (32'(pol) << 4) | 32'(en));
      wait_cyc(5);
      check(on ? "R6 wake" : "R7 no wake", 32'(pwr_en), 32'(on));
      if (on) begin
        rd(8'h98, r); check("R8 wake source", 32'(r[23:20]), 32'(src));
      end
    end
    // last vector woke with mask 0101
    // R8 source bits are read-only
    wr(8'h98, 32'h00F0_000F);
    rd(8'h98, r); check("R8 src not writable", r, 32'h0050_000F);
    // R9 pins toggle while on: no effect
    @(negedge clk); wake_pins = 4'b1010; wait_cyc(5);
    check("R9 pwr stays on", 32'(pwr_en), 1);
    rd(8'h98, r); check("R9 src held", 32'(r[23:20]), 32'h5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule